// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block is a small fully associative translation cache that sits in front of a page-table walker. Every entry holds one virtual-to-physical mapping for a 4 KB, 64 KB or 1 MB page, along with the size of that page. The size sets how many virtual page bits take part in the compare and how many offset bits pass through to the physical address. A lookup that hits gives a translated address one cycle after it is accepted. A lookup that misses raises a walk request and stalls further lookups until the walker returns a page base and a size. The block writes that result into the array on the cycle it arrives and also returns the translation as the response.

Software-style commands clear the array. A write to the flush-all command with bit 0 set empties the whole array, and so does a change of page-table base. A single-entry command carries a 4 KB aligned virtual address in bits [31:12] and a valid flag in bit 0. It removes every entry whose page contains that address, whatever size the entry is. When more than one entry covers a looked-up address, the block reports a multi-hit fault on a separate read or write line instead of translating. When the array is full, a fill replaces the least recently used entry.

The controller has two states. In LOOKUP it accepts requests. The transition "miss" moves it to WAIT_WALK. In WAIT_WALK it holds the walk request until the transition "walk_return" (walk result present) fills the array and moves it back to LOOKUP.

Top module: `xtlb_top`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid`, `walk_req` and both fault lines are 0, and the array is empty, so the first lookup misses.
- R2: A lookup accepted (`req_valid` with `req_ready`) that matches exactly one entry gives `resp_valid`=1, `resp_hit`=1 and the translated address on the cycle after the accepting edge, and raises no walk.
- R3: A lookup accepted that matches no entry raises `walk_req` on the next cycle with `walk_vaddr` equal to the missed address. `req_ready` stays 0 while `walk_req` is 1.
- R4: While waiting for the walker, `req_valid` is ignored. `walk_done` fills the entry and gives `resp_valid`=1, `resp_hit`=0 with the translated address on the next cycle. After that `walk_req` drops and `req_ready` returns to 1.
- R5: `walk_size` code 0 means 4 KB, 1 means 64 KB and 2 means 1 MB. The physical address takes the page base bits above the page offset (bit 12, 16 or 20) and the virtual address bits below it. A lookup matches an entry when the address bits at or above that page's offset are equal.
- R6: `flush_wr` with `flush_data[0]`=1 removes every entry. With `flush_data[0]`=0 it has no effect.
- R7: `inval_wr` with `inval_data[0]`=1 removes each entry whose page contains the address `inval_data[31:12]`<<12 and leaves all other entries in place. With bit 0 = 0 it has no effect.
- R8: A `ptbase_wr` pulse removes every entry.
- R9: An accepted lookup that matches two or more entries gives `resp_valid`=1 and `resp_hit`=0 on the next cycle. It also raises `mh_fault_wr` if `req_write` was 1, otherwise `mh_fault_rd`. It starts no walk and does not change recency.
- R10: When all entries are valid, a fill replaces the entry whose last hit or fill is oldest. A hit counts as a use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be accepted (LOOKUP state) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request comes from the write channel |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Response came from a cache hit |
| resp_paddr | output | 32 | Translated physical address |
| mh_fault_rd | output | 1 | Multi-hit on a read lookup |
| mh_fault_wr | output | 1 | Multi-hit on a write lookup |
| walk_req | output | 1 | Walk requested, held until result |
| walk_vaddr | output | 32 | Address for the walker |
| walk_done | input | 1 | Walker result present |
| walk_pbase | input | 32 | Physical page base from the walker |
| walk_size | input | 2 | Page size code of the result |
| flush_wr | input | 1 | Flush-all command strobe |
| flush_data | input | 32 | Flush-all command value (bit 0 acts) |
| inval_wr | input | 1 | Single-entry invalidate strobe |
| inval_data | input | 32 | Address [31:12], valid flag [0] |
| ptbase_wr | input | 1 | Page-table base changed |

## Verification
The response to an accepted lookup, whether a hit or a multi-hit fault, is due one cycle after the accepting rising edge. A miss shows as `walk_req` in that same cycle. The fill response is due one cycle after the edge that samples `walk_done`. A flush or invalidate acts on lookups accepted from the following edge onward. The bench advances a behavioural model of the recency-ordered mapping list just before each rising edge, using the inputs it has driven. After the following falling edge it compares every output against that model, so each result is checked in exactly the cycle in which it is due.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;

    localparam int VA_W  = 32;
    localparam int VPN_W = 20;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        pg_size_e         size;
        logic [VPN_W-1:0] ppn;
    } tlb_ent_t;

    function automatic pg_size_e size_decode(input logic [1:0] code);
        case (code)
            2'd1:    return PG_64K;
            2'd2:    return PG_1M;
            default: return PG_4K;
        endcase
    endfunction

    // page-number bits that take part in the compare for a given size
    function automatic logic [VPN_W-1:0] vpn_mask(input pg_size_e s);
        case (s)
            PG_1M:   return 20'hFFF00;
            PG_64K:  return 20'hFFFF0;
            default: return 20'hFFFFF;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] xlate(input tlb_ent_t e, input logic [VA_W-1:0] va);
        logic [VPN_W-1:0] m;
        m = vpn_mask(e.size);
        return {(e.ppn & m) | (va[VA_W-1:12] & ~m), va[11:0]};
    endfunction

endpackage

// File: rtl/xtlb_array.sv
module xtlb_array
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [VPN_W-1:0]    inv_vpn,
    input  logic                inv_en,
    input  logic                kill_all,
    input  logic                fill_en,
    input  logic [IDX_W-1:0]    fill_idx,
    input  tlb_ent_t            fill_ent,
    output logic [ENTRIES-1:0]  lk_match,
    output logic [ENTRIES-1:0]  valid,
    output tlb_ent_t            sel_ent
);

    tlb_ent_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] inv_hit;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic fill_here;
        assign fill_here   = fill_en && (fill_idx == IDX_W'(i));
        assign lk_match[i] = valid_q[i] &&
                             (((ent_q[i].vpn ^ lk_vpn) & vpn_mask(ent_q[i].size)) == '0);
        assign inv_hit[i]  = valid_q[i] &&
                             (((ent_q[i].vpn ^ inv_vpn) & vpn_mask(ent_q[i].size)) == '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                ent_q[i]   <= '0;
            end else begin
                if (kill_all)
                    valid_q[i] <= 1'b0;
                else if (fill_here)
                    valid_q[i] <= 1'b1;
                else if (inv_en && inv_hit[i])
                    valid_q[i] <= 1'b0;
                if (fill_here)
                    ent_q[i] <= fill_ent;
            end
        end
    end

    always_comb begin
        sel_ent = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (lk_match[i])
                sel_ent = sel_ent | ent_q[i];
    end

    assign valid = valid_q;

    // R6 R8
    kill_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_all |=> (valid_q == '0));

    // R7
    inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !fill_en && (inv_hit != '0)) |=> ((valid_q & $past(inv_hit)) == '0));

endmodule

// File: rtl/xtlb_lru.sv
module xtlb_lru #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // age 0 = most recent; ages always form a permutation of 0..ENTRIES-1
    logic [IDX_W-1:0] age_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n)
                age_q[i] <= IDX_W'(i);
            else if (touch_en) begin
                if (touch_idx == IDX_W'(i))
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (!valid[i] && !found) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        if (!found)
            for (int i = 0; i < ENTRIES; i++)
                if (age_q[i] == OLDEST)
                    victim_idx = IDX_W'(i);
    end

    logic [ENTRIES-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < ENTRIES; i++)
            seen[age_q[i]] = 1'b1;
    end

    // R10
    ages_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == ENTRIES);

    // R10
    touch_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (age_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/xtlb_top.sv
module xtlb_top
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    output logic        resp_valid,
    output logic        resp_hit,
    output logic [31:0] resp_paddr,
    output logic        mh_fault_rd,
    output logic        mh_fault_wr,
    output logic        walk_req,
    output logic [31:0] walk_vaddr,
    input  logic        walk_done,
    input  logic [31:0] walk_pbase,
    input  logic [1:0]  walk_size,
    input  logic        flush_wr,
    input  logic [31:0] flush_data,
    input  logic        inval_wr,
    input  logic [31:0] inval_data,
    input  logic        ptbase_wr
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef enum logic [0:0] {
        ST_LOOKUP    = 1'b0,
        ST_WAIT_WALK = 1'b1
    } st_e;

    st_e               state_q, state_d;
    logic [31:0]       wait_va_q;
    logic [ENTRIES-1:0] lk_match, valid;
    tlb_ent_t          sel_ent, fill_ent;
    logic [IDX_W-1:0]  victim_idx, hit_idx, touch_idx;
    logic [IDX_W:0]    match_cnt;
    logic              accept, single, multi, miss;
    logic              fill_en, touch_en, kill_all, inv_en;

    assign accept   = req_valid && (state_q == ST_LOOKUP);
    assign kill_all = ptbase_wr || (flush_wr && flush_data[0]);
    assign inv_en   = inval_wr && inval_data[0];
    assign fill_en  = (state_q == ST_WAIT_WALK) && walk_done;

    always_comb begin
        match_cnt = '0;
        hit_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            match_cnt = match_cnt + {{IDX_W{1'b0}}, lk_match[i]};
            if (lk_match[i])
                hit_idx = IDX_W'(i);
        end
    end

    assign single = (match_cnt == 1);
    assign multi  = (match_cnt > 1);
    assign miss   = (match_cnt == 0);

    assign fill_ent.vpn  = wait_va_q[31:12];
    assign fill_ent.size = size_decode(walk_size);
    assign fill_ent.ppn  = walk_pbase[31:12];

    assign touch_en  = fill_en || (accept && single);
    assign touch_idx = fill_en ? victim_idx : hit_idx;

    xtlb_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vaddr[31:12]),
        .inv_vpn  (inval_data[31:12]),
        .inv_en   (inv_en),
        .kill_all (kill_all),
        .fill_en  (fill_en),
        .fill_idx (victim_idx),
        .fill_ent (fill_ent),
        .lk_match (lk_match),
        .valid    (valid),
        .sel_ent  (sel_ent)
    );

    xtlb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid      (valid),
        .victim_idx (victim_idx)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP:    if (accept && miss) state_d = ST_WAIT_WALK;
            ST_WAIT_WALK: if (walk_done)      state_d = ST_LOOKUP;
            default:                          state_d = ST_LOOKUP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_LOOKUP;
            wait_va_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && miss)
                wait_va_q <= req_vaddr;
        end
    end

    // registered responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_paddr  <= '0;
            mh_fault_rd <= 1'b0;
            mh_fault_wr <= 1'b0;
        end else begin
            resp_valid  <= fill_en || (accept && !miss);
            resp_hit    <= accept && single;
            mh_fault_rd <= accept && multi && !req_write;
            mh_fault_wr <= accept && multi && req_write;
            if (fill_en)
                resp_paddr <= xlate(fill_ent, wait_va_q);
            else if (accept && single)
                resp_paddr <= xlate(sel_ent, req_vaddr);
            else
                resp_paddr <= '0;
        end
    end

    assign req_ready  = (state_q == ST_LOOKUP);
    assign walk_req   = (state_q == ST_WAIT_WALK);
    assign walk_vaddr = wait_va_q;

    // R3
    walk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !req_ready);

    // R4
    fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_done) |=> (resp_valid && !resp_hit && !walk_req));

    // R9
    mh_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mh_fault_rd, mh_fault_wr}));

    // R9
    mh_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mh_fault_rd || mh_fault_wr) |-> (resp_valid && !resp_hit && !walk_req));

    // R2
    hit_nowalk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (resp_valid && !walk_req));

endmodule

// File: tb/xtlb_top_test.sv
module xtlb_top_test;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, walk_done = 0;
    logic        flush_wr = 0, inval_wr = 0, ptbase_wr = 0;
    logic [31:0] req_vaddr = 0, walk_pbase = 0, flush_data = 0, inval_data = 0;
    logic [1:0]  walk_size = 0;
    logic        req_ready, resp_valid, resp_hit, mh_fault_rd, mh_fault_wr, walk_req;
    logic [31:0] resp_paddr, walk_vaddr;

    always #10 clk = ~clk;

    xtlb_top #(.ENTRIES(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
        .mh_fault_rd(mh_fault_rd), .mh_fault_wr(mh_fault_wr),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr),
        .walk_done(walk_done), .walk_pbase(walk_pbase), .walk_size(walk_size),
        .flush_wr(flush_wr), .flush_data(flush_data),
        .inval_wr(inval_wr), .inval_data(inval_data), .ptbase_wr(ptbase_wr)
    );

    int    checks = 0, errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // model: index 0 is least recently used
    bit [19:0] m_tag[$];
    int        m_sz[$];
    bit [19:0] m_ppn[$];
    bit        m_wait = 0;
    bit [31:0] m_wva = 0;
    bit        e_rv, e_hit, e_mr, e_mw;
    bit [31:0] e_pa;

    function automatic bit [19:0] msk(int sz);
        if (sz == 2) return 20'hFFF00;
        if (sz == 1) return 20'hFFFF0;
        return 20'hFFFFF;
    endfunction

    function automatic bit [31:0] phys(bit [19:0] ppn, int sz, bit [31:0] va);
        bit [19:0] m = msk(sz);
        return {(ppn & m) | (va[31:12] & ~m), va[11:0]};
    endfunction

    function automatic bit covers(int k, bit [19:0] vpn);
        return ((m_tag[k] ^ vpn) & msk(m_sz[k])) == 0;
    endfunction

    task automatic model_step();
        e_rv = 0; e_hit = 0; e_mr = 0; e_mw = 0; e_pa = 0;
        if (!m_wait && req_valid) begin
            int cnt = 0, at = -1;
            for (int k = 0; k < m_tag.size(); k++)
                if (covers(k, req_vaddr[31:12])) begin cnt++; at = k; end
            if (cnt == 1) begin
                bit [19:0] t = m_tag[at]; int s = m_sz[at]; bit [19:0] p = m_ppn[at];
                e_rv = 1; e_hit = 1; e_pa = phys(p, s, req_vaddr);
                m_tag.delete(at); m_sz.delete(at); m_ppn.delete(at);
                m_tag.push_back(t); m_sz.push_back(s); m_ppn.push_back(p);
            end else if (cnt > 1) begin
                e_rv = 1; e_mr = !req_write; e_mw = req_write;
            end else begin
                m_wait = 1; m_wva = req_vaddr;
            end
        end else if (m_wait && walk_done) begin
            int s = (walk_size == 2'd1) ? 1 : (walk_size == 2'd2) ? 2 : 0;
            if (m_tag.size() == DEPTH) begin
                void'(m_tag.pop_front()); void'(m_sz.pop_front()); void'(m_ppn.pop_front());
            end
            m_tag.push_back(m_wva[31:12]); m_sz.push_back(s); m_ppn.push_back(walk_pbase[31:12]);
            e_rv = 1; e_pa = phys(walk_pbase[31:12], s, m_wva);
            m_wait = 0;
        end
        if (ptbase_wr || (flush_wr && flush_data[0])) begin
            m_tag.delete(); m_sz.delete(); m_ppn.delete();
        end
        if (inval_wr && inval_data[0])
            for (int k = m_tag.size() - 1; k >= 0; k--)
                if (covers(k, inval_data[31:12])) begin
                    m_tag.delete(k); m_sz.delete(k); m_ppn.delete(k);
                end
    endtask

    task automatic chk(string f, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, f, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("req_ready", 32'(req_ready), 32'(!m_wait));
        chk("walk_req", 32'(walk_req), 32'(m_wait));
        if (m_wait) chk("walk_vaddr", walk_vaddr, m_wva);
        chk("resp_valid", 32'(resp_valid), 32'(e_rv));
        chk("resp_hit", 32'(resp_hit), 32'(e_hit));
        chk("mh_fault_rd", 32'(mh_fault_rd), 32'(e_mr));
        chk("mh_fault_wr", 32'(mh_fault_wr), 32'(e_mw));
        if (e_rv && !e_mr && !e_mw) chk("resp_paddr", resp_paddr, e_pa);
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0; walk_done = 0;
        flush_wr = 0; inval_wr = 0; ptbase_wr = 0;
        compare();
    endtask

    task automatic lookup(bit [31:0] va, bit wr = 0);
        req_valid = 1; req_vaddr = va; req_write = wr; cyc();
    endtask

    task automatic walk(bit [31:0] pb, bit [1:0] sz);
        walk_done = 1; walk_pbase = pb; walk_size = sz; cyc();
    endtask

    task automatic flush_all(bit [31:0] v);
        flush_wr = 1; flush_data = v; cyc();
    endtask

    task automatic inval(bit [31:0] v);
        inval_wr = 1; inval_data = v; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1"; compare();
        cyc();
        lookup(32'h0000_1000);                    // R1 empty: miss
        walk(32'h8800_0000, 2'd0);

        cur_req = "R3"; lookup(32'h0001_2345);
        cur_req = "R4";
        req_valid = 1; req_vaddr = 32'h0001_2345; cyc();   // ignored while waiting
        walk(32'h8000_0000, 2'd0);
        cur_req = "R2"; lookup(32'h0001_2FFF);
        lookup(32'h0001_3000);                    // different 4K page: miss
        cur_req = "R4"; walk(32'h8100_0000, 2'd0);

        cur_req = "R5";
        lookup(32'h0045_1234); walk(32'hA007_0000, 2'd1);
        lookup(32'h0045_F00C);
        lookup(32'h1234_5678); walk(32'hB000_0000, 2'd2);
        lookup(32'h123F_FFFC);
        lookup(32'h0046_0000); walk(32'hA008_0000, 2'd0);

        cur_req = "R6";
        flush_all(32'h0000_0000);
        lookup(32'h0045_1234);
        flush_all(32'h0000_0001);
        lookup(32'h0045_1234); walk(32'hA007_0000, 2'd1);

        cur_req = "R7";
        lookup(32'h0002_0010); walk(32'h8200_0000, 2'd0);
        lookup(32'h0003_0020); walk(32'h8300_0000, 2'd1);
        inval(32'h0002_0000);                     // flag clear: no effect
        lookup(32'h0002_0010);
        inval(32'h0003_5001);                     // inside the 64 KB page
        lookup(32'h0002_0010);
        lookup(32'h0003_0020); walk(32'h8400_0000, 2'd0);

        cur_req = "R8";
        ptbase_wr = 1; cyc();
        lookup(32'h0002_0010); walk(32'h8200_0000, 2'd0);

        cur_req = "R9";
        flush_all(32'h1);
        lookup(32'h0034_5ABC); walk(32'h8000_1000, 2'd0);
        lookup(32'h0030_0123); walk(32'h9000_0000, 2'd2);
        lookup(32'h0034_5ABC, 1'b0);
        lookup(32'h0034_5ABC, 1'b1);
        cur_req = "R7";
        inval(32'h0034_5001);                     // removes both sizes
        lookup(32'h0034_5ABC); walk(32'h8000_2000, 2'd0);

        cur_req = "R10";
        flush_all(32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            lookup(32'h0100_0000 + 32'(i) * 32'h1000);
            walk(32'hC000_0000 + 32'(i) * 32'h1000, 2'd0);
        end
        lookup(32'h0100_0004);                    // make page 0 recent
        lookup(32'h0200_0000); walk(32'hD000_0000, 2'd0);
        lookup(32'h0100_0008);                    // page 0 survives
        lookup(32'h0100_1008);                    // page 1 was evicted
        walk(32'hC000_1000, 2'd0);
        lookup(32'h0100_2000);                    // page 2 now evicted
        walk(32'hC000_2000, 2'd0);
        cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule